// File: doc/BRIEF.md
# Preloadable Up-Counting Interval Timer

This block is a periodic interrupt source built around a 16-bit counter that climbs from a programmable start value. A divider on the system clock produces a one-cycle tick enable at the timer rate (160 kHz in the intended system). Each tick moves the counter up by one. When a tick finds the counter at its all-ones value, the counter is reloaded from the start value and a pending flag is raised. A rate of f interrupts per second therefore needs a start value of 65536 - 160000/f; for example, 63936 gives 100 Hz.

Software writes three registers through a simple write strobe and a 2-bit select. The first is the start value. The second is a 2-bit run/halt/clear code. The third is an interrupt-control byte that holds a 3-bit request level, an enable bit and a write-one-to-acknowledge bit. The live count and an interrupt status byte are visible on output ports at all times.

A three-state machine decides whether ticks reach the counter: CLEARED (the reset state, count forced to zero), HELD (count frozen) and RUNNING. Transitions: any state goes to CLEARED on the clear code, to HELD on the halt code, and to RUNNING on the run code. The unused code leaves the state as it is.

Top module: `interval_timer`

## Requirements
- R1: After reset the count is 0, the machine is CLEARED, the pending flag is 0, the interrupt level and enable are 0, `irq_req_o` is 0 and `irq_level_o` is 0.
- R2: While RUNNING, the count rises by exactly one every `TICK_DIV` clock cycles. The first step lands `TICK_DIV` clock edges after the edge that accepted the run code.
- R3: A tick that finds the count at 0xFFFF loads the stored start value on that same edge and sets the pending flag (`stat_o[7]`).
- R4: Writing control code 0 (`wr_sel`=1, `wr_data[1:0]`=0) sets the count to 0 on the next edge and enters CLEARED.
- R5: Control code 1 enters HELD and keeps the count unchanged. A later run code resumes counting, with the first step `TICK_DIV` edges after that write.
- R6: Control code 3 enters RUNNING. Code 2 changes nothing, and code 3 written while already RUNNING does not disturb the tick phase.
- R7: A start-value write (`wr_sel`=0) while not RUNNING also loads the count. While RUNNING it changes only the value used at the next wrap.
- R8: An interrupt-control write (`wr_sel`=2) stores the level from `wr_data[2:0]` and the enable from `wr_data[3]`. `stat_o` reads back as {pending, 3'b000, enable, level[2:0]}.
- R9: An interrupt-control write with `wr_data[7]`=1 clears the pending flag. If a wrap occurs on the same edge, the flag stays set.
- R10: `irq_req_o` is 1 exactly when pending, enable and a nonzero level are all present. `irq_level_o` then carries the level and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Target: 0 start value, 1 control code, 2 interrupt control, 3 none |
| wr_data | input | CNT_W | Write data |
| count_o | output | CNT_W | Live counter value |
| stat_o | output | 8 | Interrupt status {pending, 000, enable, level} |
| irq_req_o | output | 1 | Interrupt request |
| irq_level_o | output | 3 | Request level, 0 when no request |

## Verification
The hardest case to reach is an acknowledge write that lands on the very edge where the counter wraps. Here the set must beat the clear. The bench counts clock edges from the edge that accepted the run code and computes the wrap edge as that edge plus `TICK_DIV` times the period in ticks. It then times the acknowledge write to fall on exactly that edge. The same edge bookkeeping lets every count in the start-value sweep be predicted arithmetically, including a start value changed mid-run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ST_CLEARED = 2'd0,
        ST_HELD    = 2'd1,
        ST_RUNNING = 2'd2
    } tmr_state_e;

    localparam logic [1:0] SEL_START = 2'd0;
    localparam logic [1:0] SEL_CTRL  = 2'd1;
    localparam logic [1:0] SEL_IRQ   = 2'd2;

    localparam logic [1:0] CMD_CLEAR = 2'd0;
    localparam logic [1:0] CMD_HALT  = 2'd1;
    localparam logic [1:0] CMD_RUN   = 2'd3;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!enable) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = enable && (phase_q == LAST);
endmodule

// File: rtl/tmr_ctrl_fsm.sv
module tmr_ctrl_fsm
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd,
    output tmr_state_e state_o,
    output logic       run_o,
    output logic       clear_o
);
    tmr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEARED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (cmd_valid) begin
            unique case (cmd)
                CMD_CLEAR: state_d = ST_CLEARED;
                CMD_HALT:  state_d = ST_HELD;
                CMD_RUN:   state_d = ST_RUNNING;
                default:   state_d = state_q;
            endcase
        end
    end

    always_comb begin
        run_o   = 1'b0;
        clear_o = cmd_valid && (cmd == CMD_CLEAR);
        unique case (state_q)
            ST_RUNNING: run_o = 1'b1;
            ST_HELD:    run_o = 1'b0;
            ST_CLEARED: run_o = 1'b0;
            default:    run_o = 1'b0;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  logic             run,
    input  logic             start_we,
    input  logic [CNT_W-1:0] start_data,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] start_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] start_q;

    assign wrap_o = tick && (count_q == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (start_we) begin
            start_q <= start_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= wrap_o ? start_q : count_q + 1'b1;
        end else if (start_we && !run) begin
            count_q <= start_data;
        end
    end

    assign count_o = count_q;
    assign start_o = start_q;
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_data,
    input  logic             wrap,
    output logic [7:0]       stat_o,
    output logic             req_o,
    output logic [LVL_W-1:0] level_o
);
    logic [LVL_W-1:0] level_q;
    logic             en_q;
    logic             pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
            en_q    <= 1'b0;
        end else if (cfg_we) begin
            level_q <= cfg_data[LVL_W-1:0];
            en_q    <= cfg_data[3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (wrap) begin
            pend_q <= 1'b1;
        end else if (cfg_we && cfg_data[7]) begin
            pend_q <= 1'b0;
        end
    end

    assign req_o   = pend_q && en_q && (level_q != '0);
    assign level_o = req_o ? level_q : '0;
    assign stat_o  = {pend_q, 3'b000, en_q, 3'(level_q)};
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int TICK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic [7:0]       stat_o,
    output logic             irq_req_o,
    output logic [2:0]       irq_level_o
);
    localparam int LVL_W = 3;

    tmr_state_e       state_w;
    logic             run_w;
    logic             clear_w;
    logic             tick_w;
    logic             wrap_w;
    logic [CNT_W-1:0] start_w;

    tmr_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (wr_en && (wr_sel == SEL_CTRL)),
        .cmd       (wr_data[1:0]),
        .state_o   (state_w),
        .run_o     (run_w),
        .clear_o   (clear_w)
    );

    tmr_prescale #(.DIV(TICK_DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (run_w),
        .tick   (tick_w)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_w),
        .clear      (clear_w),
        .run        (run_w),
        .start_we   (wr_en && (wr_sel == SEL_START)),
        .start_data (wr_data),
        .count_o    (count_o),
        .start_o    (start_w),
        .wrap_o     (wrap_w)
    );

    tmr_irq #(.LVL_W(LVL_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (wr_en && (wr_sel == SEL_IRQ)),
        .cfg_data (wr_data[7:0]),
        .wrap     (wrap_w),
        .stat_o   (stat_o),
        .req_o    (irq_req_o),
        .level_o  (irq_level_o)
    );
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] count_o,
    input logic [7:0]       stat_o,
    input logic             irq_req_o,
    input logic [2:0]       irq_level_o,
    input logic             tick,
    input logic             run,
    input logic [CNT_W-1:0] start_val
);
    logic clr_wr, ctl_wr, st_wr, ack_wr, at_top;
    assign ctl_wr = wr_en && (wr_sel == 2'd1);
    assign clr_wr = ctl_wr && (wr_data[1:0] == 2'd0);
    assign st_wr  = wr_en && (wr_sel == 2'd0);
    assign ack_wr = wr_en && (wr_sel == 2'd2) && wr_data[7];
    assign at_top = (count_o == {CNT_W{1'b1}});

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !at_top && !clr_wr) |=> (count_o == CNT_W'($past(count_o) + 1'b1)));

    p_wrap_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_top && !clr_wr) |=> (count_o == $past(start_val) && stat_o[7]));

    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (count_o == '0));

    p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ctl_wr && !st_wr) |=> $stable(count_o));

    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !(tick && at_top)) |=> !stat_o[7]);

    p_req_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (stat_o[7] && stat_o[3] && stat_o[2:0] != 3'd0 && irq_level_o == stat_o[2:0]));

    p_idle_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req_o |-> (irq_level_o == 3'd0));
endmodule

bind interval_timer interval_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .count_o     (count_o),
    .stat_o      (stat_o),
    .irq_req_o   (irq_req_o),
    .irq_level_o (irq_level_o),
    .tick        (tick_w),
    .run         (run_w),
    .start_val   (start_w)
);

// File: tb/interval_timer_test.sv
module interval_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [15:0] wr_data = '0;
    logic [15:0] count_o;
    logic [7:0]  stat_o;
    logic        irq_req_o;
    logic [2:0]  irq_level_o;

    int total = 0;
    int bad = 0;
    int edges = 0;
    int run_edge = 0;
    bit done = 1'b0;

    interval_timer #(.CNT_W(16), .TICK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .count_o(count_o), .stat_o(stat_o),
        .irq_req_o(irq_req_o), .irq_level_o(irq_level_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) edges <= edges + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at edge %0d", req, act, exp, edges);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    endtask

    task automatic start_run();
        wr(2'd1, 16'd3);
        run_edge = edges;
    endtask

    task automatic to_edge(input int target);
        while (edges < target) begin
            @(posedge clk); #1;
        end
    endtask

    function automatic logic [15:0] model(input int p0, input int p1, input int t);
        int l0 = 65536 - p0;
        int l1 = 65536 - p1;
        if (t < l0) return 16'(p0 + t);
        return 16'(p1 + ((t - l0) % l1));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 count", 32'(count_o), 32'd0);
        chk("R1 stat", 32'(stat_o), 32'd0);
        chk("R1 req", 32'(irq_req_o), 32'd0);
        chk("R1 level", 32'(irq_level_o), 32'd0);
        repeat (5) @(negedge clk);
        chk("R1 idle count stays", 32'(count_o), 32'd0);

        // Sweep of start values near the top: R2, R3, R7, R8, R10
        for (int p = 16'hFFF0; p <= 16'hFFFF; p++) begin
            int l;
            l = 65536 - p;
            wr(2'd1, 16'd0);
            chk("R4 clear", 32'(count_o), 32'd0);
            wr(2'd2, 16'h008D);
            chk("R8 stat readback", 32'(stat_o), 32'h0D);
            wr(2'd0, 16'(p));
            chk("R7 load while stopped", 32'(count_o), 32'(p));
            start_run();
            for (int k = 1; k <= DIV * (2 * l + 3); k++) begin
                int t;
                @(posedge clk); #1;
                t = (edges - run_edge) / DIV;
                chk("R2/R3 count", 32'(count_o), 32'(model(p, p, t)));
                chk("R3 pending", 32'(stat_o[7]), 32'(t >= l));
                chk("R10 req", 32'(irq_req_o), 32'(t >= l));
                chk("R10 level", 32'(irq_level_o), (t >= l) ? 32'd5 : 32'd0);
            end
        end

        // R5: halt keeps count, resume restarts tick phase
        wr(2'd1, 16'd0);
        wr(2'd0, 16'hFFF0);
        start_run();
        to_edge(run_edge + 9);
        wr(2'd1, 16'd1);
        chk("R5 halted value", 32'(count_o), 32'hFFF2);
        repeat (20) @(negedge clk);
        chk("R5 frozen", 32'(count_o), 32'hFFF2);
        start_run();
        to_edge(run_edge + DIV - 1);
        chk("R5 no early step", 32'(count_o), 32'hFFF2);
        to_edge(run_edge + DIV);
        chk("R5 first step after resume", 32'(count_o), 32'hFFF3);

        // R4: clear while running
        wr(2'd1, 16'd0);
        chk("R4 clear running", 32'(count_o), 32'd0);
        repeat (3 * DIV) @(negedge clk);
        chk("R4 stays cleared", 32'(count_o), 32'd0);

        // R6: code 2 and repeated run have no effect; R7 start change mid-run
        wr(2'd0, 16'hFFF0);
        start_run();
        to_edge(run_edge + 5);
        wr(2'd1, 16'd2);
        wr(2'd1, 16'd3);
        wr(2'd0, 16'hFFF8);
        for (int k = 0; k < DIV * 30; k++) begin
            int t;
            @(posedge clk); #1;
            t = (edges - run_edge) / DIV;
            chk("R6/R7 count", 32'(count_o), 32'(model(16'hFFF0, 16'hFFF8, t)));
        end

        // R9: acknowledge alone, then acknowledge on the wrap edge
        wr(2'd1, 16'd0);
        wr(2'd2, 16'h008D);
        wr(2'd0, 16'hFFFC);
        start_run();
        to_edge(run_edge + DIV * 4 + 1);
        chk("R9 pending before ack", 32'(stat_o[7]), 32'd1);
        wr(2'd2, 16'h008D);
        chk("R9 ack clears", 32'(stat_o[7]), 32'd0);
        chk("R10 req after ack", 32'(irq_req_o), 32'd0);
        to_edge(run_edge + DIV * 8 - 1);
        chk("R9 no pending before wrap", 32'(stat_o[7]), 32'd0);
        wr(2'd2, 16'h008D);
        chk("R9 wrap beats ack", 32'(stat_o[7]), 32'd1);

        // R10: gating by enable and level
        wr(2'd2, 16'h0005);
        chk("R10 disabled req", 32'(irq_req_o), 32'd0);
        chk("R8 enable off readback", 32'(stat_o), 32'h85);
        wr(2'd2, 16'h0008);
        chk("R10 level zero req", 32'(irq_req_o), 32'd0);
        chk("R10 level zero out", 32'(irq_level_o), 32'd0);
        wr(2'd2, 16'h000F);
        chk("R10 req", 32'(irq_req_o), 32'd1);
        chk("R10 level", 32'(irq_level_o), 32'd7);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule